// File: doc/BRIEF.md
# Readback Frame Word Deserializer

This block sits behind the serial output of a configuration readback shift. It takes the bit stream one bit at a time, most significant bit of each word first, and packs it into 32-bit words. The device's frame buffer places one frame of meaningless data ahead of the real frames. The block counts words against a programmable frame length and drops that whole first frame. Every word after it goes out on a valid/ready word stream.

The bit stream ends with a bit flagged as the final one, which is the bit shifted while the scan controller leaves its data-shift state. The word that this bit completes carries a last marker. Software-side setup supplies the requested word count, which is the count written in the long-form read packet header and includes the dropped frame. The block compares this count with the number of words actually received. Two sticky error flags report a stream that stops in the middle of a word and a stream whose length does not match the requested count. A trailing partial word is never emitted.

A synchronous `clear` starts each readback: it empties the output register, zeroes the bit and word counters, and drops both error flags. On the input side the bit is taken on a cycle with `in_valid` and `in_ready` both high. On the output side a word moves on a cycle with `out_valid` and `out_ready` both high. While `out_valid` is high and `out_ready` is low, the word and its marker hold still. The input is stalled only on the bit that would complete a new word while the output register is still occupied.

Top module: `readback_deserializer`

## Requirements
- R1: After reset, and in the cycle after `clear`, `out_valid`, `err_partial` and `err_len` are 0. After reset `in_ready` is 1. `clear` also restarts bit and word counting.
- R2: Accepted bits are packed into WORD_W-bit words. The first accepted bit of each word becomes bit WORD_W-1 of `out_data` and the last becomes bit 0.
- R3: The first `frame_words` complete words after a clear are discarded. A value of 0 discards nothing.
- R4: The words that are not discarded appear on `out_data` in arrival order, each exactly once. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged.
- R5: `out_last` is 1 only on the word completed by the bit accepted with `in_last` high. No word follows it before the next clear.
- R6: If the bit flagged `in_last` does not complete a word, the partial word is not emitted and `err_partial` rises and stays 1 until clear.
- R7: If the bit flagged `in_last` completes word number n (counting from 1, dropped words included) and n differs from `total_words`, `err_len` rises and stays 1 until clear. It stays 0 whenever R6 applies.
- R8: After the bit flagged `in_last` is accepted, `in_ready` stays 0 and no further bit is taken until clear.
- R9: When the next accepted bit would complete a word while `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. It is 1 at every other point of an unfinished stream outside clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous restart at the start of a readback |
| frame_words | input | CNT_W | Length of the discarded leading frame, in words |
| total_words | input | CNT_W | Requested word count, dummy frame included |
| in_valid | input | 1 | Serial bit present |
| in_ready | output | 1 | Serial bit can be taken this cycle |
| in_bit | input | 1 | Serial data bit |
| in_last | input | 1 | Marks the final bit of the stream |
| out_valid | output | 1 | Word present on out_data |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | WORD_W | Assembled word, first received bit in the MSB |
| out_last | output | 1 | Word is the final word of the stream |
| err_partial | output | 1 | Stream ended inside a word (sticky) |
| err_len | output | 1 | Word count differs from total_words (sticky) |

## Verification
The bench sweeps dummy-frame lengths from zero to three words against streams of one to five whole words. Some of these streams are exact and some end nine bits into an unfinished word. This separates a correct discard boundary from off-by-one drops, and a clean last-word end from a partial-word error. Each combination runs once with free-flowing handshakes and once with periodic input gaps and output stalls. The stalled runs show whether back-pressure loses or repeats words and whether the input is held off at the word boundary only. Requested counts that match and that miss the received count separate the length check from the partial check. Another run feeds a few stray bits, clears, and then sends a full stream, which shows whether clear realigns the word boundary.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

  // Default widths shared by the deserializer and its checker
  parameter int unsigned RBD_WORD_W = 32;
  parameter int unsigned RBD_CNT_W  = 16;

  // Sticky end-of-stream error flags
  typedef struct packed {
    logic partial;
    logic len_mismatch;
  } rbd_err_t;

  function automatic rbd_err_t rbd_end_check(input logic word_done, input logic count_ok);
    rbd_err_t e;
    e.partial      = !word_done;
    e.len_mismatch = word_done && !count_ok;
    return e;
  endfunction

endpackage

// File: rtl/rbd_bit_packer.sv
module rbd_bit_packer #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_done_o,
  output logic              at_boundary_o
);
  localparam int unsigned POS_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(WORD_W - 1);

  logic [POS_W-1:0] pos_q;

  assign at_boundary_o = (pos_q == POS_LAST);
  assign word_done_o   = take && at_boundary_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (clear) begin
      pos_q <= '0;
    end else if (take) begin
      pos_q <= at_boundary_o ? '0 : pos_q + 1'b1;
    end
  end

  generate
    if (WORD_W > 1) begin : g_shift
      logic [WORD_W-2:0] sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr_q <= '0;
        end else if (clear) begin
          sr_q <= '0;
        end else if (take) begin
          sr_q <= at_boundary_o ? '0 : {sr_q[WORD_W-3 >= 0 ? WORD_W-3 : 0:0], bit_i};
        end
      end
      assign word_o = {sr_q, bit_i};
    end else begin : g_single
      assign word_o = bit_i;
    end
  endgenerate

endmodule

// File: rtl/rbd_frame_gate.sv
module rbd_frame_gate #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             word_done,
  input  logic [CNT_W-1:0] frame_words,
  input  logic [CNT_W-1:0] total_words,
  output logic             keep_o,
  output logic             count_ok_o
);
  localparam logic [CNT_W-1:0] IDX_MAX = '1;

  logic [CNT_W-1:0] idx_q;
  logic [CNT_W:0]   ordinal;

  // Words before index frame_words belong to the dummy frame
  assign keep_o     = (idx_q >= frame_words);
  assign ordinal    = {1'b0, idx_q} + 1'b1;
  assign count_ok_o = (ordinal == {1'b0, total_words});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clear) begin
      idx_q <= '0;
    end else if (word_done && idx_q != IDX_MAX) begin
      idx_q <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/rbd_out_stage.sv
module rbd_out_stage #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [WORD_W-1:0] data_in,
  input  logic              last_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              can_load_o
);
  assign can_load_o = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (clear) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= data_in;
      out_last  <= last_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

endmodule

// File: rtl/readback_deserializer.sv
module readback_deserializer
  import rbd_pkg::*;
#(
  parameter int unsigned WORD_W = RBD_WORD_W,
  parameter int unsigned CNT_W  = RBD_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [CNT_W-1:0]  frame_words,
  input  logic [CNT_W-1:0]  total_words,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              err_partial,
  output logic              err_len
);
  logic              take;
  logic              word_done;
  logic              at_boundary;
  logic [WORD_W-1:0] word;
  logic              keep;
  logic              count_ok;
  logic              can_load;
  logic              done_q;
  rbd_err_t          err_q;
  rbd_err_t          err_new;

  // A stall is needed only on the bit that would finish a word
  assign in_ready = !clear && !done_q && (!at_boundary || can_load);
  assign take     = in_valid && in_ready;

  rbd_bit_packer #(.WORD_W(WORD_W)) packer_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (clear),
    .take         (take),
    .bit_i        (in_bit),
    .word_o       (word),
    .word_done_o  (word_done),
    .at_boundary_o(at_boundary)
  );

  rbd_frame_gate #(.CNT_W(CNT_W)) gate_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .word_done  (word_done),
    .frame_words(frame_words),
    .total_words(total_words),
    .keep_o     (keep),
    .count_ok_o (count_ok)
  );

  rbd_out_stage #(.WORD_W(WORD_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .load      (word_done && keep),
    .data_in   (word),
    .last_in   (in_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .can_load_o(can_load)
  );

  assign err_new = rbd_end_check(word_done, count_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= '0;
    end else if (clear) begin
      done_q <= 1'b0;
      err_q  <= '0;
    end else if (take && in_last) begin
      done_q <= 1'b1;
      err_q  <= err_q | err_new;
    end
  end

  assign err_partial = err_q.partial;
  assign err_len     = err_q.len_mismatch;

endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_last,
  input logic              err_partial,
  input logic              err_len
);

  a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!out_valid && !err_partial && !err_len));

  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clear) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r5_nothing_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && out_ready && !clear) |=> !out_valid);

  a_r6_partial_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_partial && !clear) |=> err_partial);

  a_r7_len_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_len && !clear) |=> err_len);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_len && err_partial));

  a_r8_closed_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && !clear) |=> !in_ready);

endmodule

bind readback_deserializer rbd_checker #(.WORD_W(WORD_W)) chk_i (.*);

// File: tb/readback_deserializer_tb_top.sv
`timescale 1ns/1ps
module readback_deserializer_tb_top;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 16;
  localparam int WATCHDOG = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clear = 1'b0;
  logic [CNT_W-1:0]  frame_words = '0;
  logic [CNT_W-1:0]  total_words = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              in_bit = 1'b0;
  logic              in_last = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [WORD_W-1:0] out_data;
  logic              out_last;
  logic              err_partial;
  logic              err_len;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  readback_deserializer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .frame_words(frame_words), .total_words(total_words),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .err_partial(err_partial), .err_len(err_len)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_word(input int seed, input int k);
    return (32'h9E3779B9 * (k + 1)) ^ (32'(seed) * 32'h01000193);
  endfunction

  function automatic logic stream_bit(input int seed, input int j);
    logic [31:0] w;
    w = gen_word(seed, j / 32);
    return w[31 - (j % 32)];
  endfunction

  task automatic pulse_clear();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic run_stream(input int fw, input int tw, input int nbits,
                            input int mode, input int pre_bits, input int seed);
    int whole;
    int rem;
    int exp_emit;
    int sent;
    int got;
    int idle;
    int cyc;
    int idx;
    bit r8_done;
    whole = nbits / 32;
    rem = nbits % 32;
    exp_emit = (whole > fw) ? whole - fw : 0;
    sent = 0; got = 0; idle = 0; cyc = 0; r8_done = 1'b0;
    frame_words = CNT_W'(fw);
    total_words = CNT_W'(tw);
    out_ready = 1'b1;
    pulse_clear();
    // R1: state right after clear
    check(!out_valid && !err_partial && !err_len, "R1", "flags after clear",
          {29'b0, out_valid, err_partial, err_len}, 32'h0);
    if (pre_bits > 0) begin
      for (int p = 0; p < pre_bits; p++) begin
        @(negedge clk);
        in_valid = 1'b1; in_bit = 1'b1; in_last = 1'b0;
      end
      pulse_clear();
    end
    while (idle < 12) begin
      @(negedge clk);
      out_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (sent < nbits && (mode == 0 || (cyc % 5) != 2)) begin
        in_valid = 1'b1;
        in_bit   = stream_bit(seed, sent);
        in_last  = (sent == nbits - 1);
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      #1;
      // R9: stall only at the word boundary while output is occupied
      if (sent < nbits && out_valid && !out_ready && (sent % 32) == 31)
        check(!in_ready, "R9", "in_ready at blocked boundary", {31'b0, in_ready}, 32'h0);
      else if (sent < nbits && mode == 0)
        check(in_ready, "R9", "in_ready mid-stream", {31'b0, in_ready}, 32'h1);
      if (out_valid && out_ready) begin
        idx = fw + got;
        check(got < exp_emit, "R3", "unexpected extra word", 32'(got), 32'(exp_emit));
        // R2 R4: content and order of the kept words
        check(out_data == gen_word(seed, idx), "R2", "word data", out_data, gen_word(seed, idx));
        check(out_last == (rem == 0 && idx == whole - 1), "R5", "last marker",
              {31'b0, out_last}, {31'b0, (rem == 0 && idx == whole - 1)});
        got++;
      end
      if (in_valid && in_ready) sent++;
      if (sent == nbits && !(in_valid && in_ready)) begin
        if (!r8_done) begin
          check(!in_ready, "R8", "in_ready after final bit", {31'b0, in_ready}, 32'h0);
          r8_done = 1'b1;
        end
        if (!out_valid) idle++;
      end
      cyc++;
    end
    in_valid = 1'b0; in_last = 1'b0;
    check(got == exp_emit, "R3", "kept word count", 32'(got), 32'(exp_emit));
    check(err_partial == (rem != 0), "R6", "partial flag",
          {31'b0, err_partial}, {31'b0, (rem != 0)});
    check(err_len == (rem == 0 && whole != tw), "R7", "length flag",
          {31'b0, err_len}, {31'b0, (rem == 0 && whole != tw)});
  endtask

  initial begin
    #12;
    @(negedge clk);
    #1;
    // R1: reset values
    check(!out_valid && !err_partial && !err_len && in_ready, "R1", "reset state",
          {28'b0, out_valid, err_partial, err_len, in_ready}, 32'h1);
    rst_n = 1'b1;
    for (int fw = 0; fw < 4; fw++)
      for (int nw = 1; nw < 6; nw++)
        for (int ex = 0; ex < 2; ex++)
          for (int md = 0; md < 2; md++)
            run_stream(fw, (md == 0) ? nw : nw + (fw % 2), nw * 32 + ex * 9, md, 0,
                       fw * 40 + nw * 4 + ex * 2 + md);
    // R10-style restart: stray bits, then clear realigns the word boundary (R1)
    run_stream(2, 4, 128, 0, 13, 777);
    run_stream(1, 3, 96, 1, 21, 555);
    // R3: a stream shorter than the dummy frame emits nothing
    run_stream(3, 2, 64, 0, 0, 99);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule